// File: doc/BRIEF.md
# Color Palette Lookup with Byte-Serial Host Port

This block holds a 256-entry table of 24-bit colors and serves two clients. A host processor loads and inspects the table through an 8-bit port. It writes an entry index once. After that it moves colors as a red, green, blue byte sequence, and the index steps on by itself after every third byte. A whole table therefore loads or reads back after a single index write. The display pipeline has its own read port. It presents an 8-bit pixel value each cycle and receives the formatted 24-bit color one cycle later, and host traffic never stalls it.

A width-compatibility control selects 8-bit or 6-bit color. In 6-bit mode the table still keeps every bit the host writes. Host read-back forces the two upper bits of each byte to zero. The pixel output lifts the six low bits of each channel into the top six positions and fills the bottom two with zero.

Top module: `palette_port`

## Requirements
- R1: After a synchronous active-low reset, the entry index is 0, the byte phase is red, `host_rdata` is 0 and `pix_rgb` is 0.
- R2: Three data writes at index A store red, green and blue as the word {red[23:16], green[15:8], blue[7:0]} at entry A. Red and green wait in holding registers, and the table is written once, when the blue byte arrives.
- R3: After the third byte of a sequence, whether read or written, the index advances by one and the phase returns to red. `host_rdata` then shows the red byte of the new entry.
- R4: When the index advances past 255 it becomes 0.
- R5: An index write sets the index to `host_wdata`, returns the phase to red and discards any held partial write, leaving the table unchanged.
- R6: Host read-back takes all three bytes from one snapshot of the entry. The snapshot is taken when the index is written or advanced. `host_rdata` shows the byte selected by the current phase.
- R7: In 6-bit mode (`mode_8bit`=0) writes still store all 8 bits. `host_rdata[7:6]` reads 0, and returning to 8-bit mode shows the stored upper bits again.
- R8: `pix_rgb` is registered and shows entry `pix_idx` one cycle after the index is presented. In 8-bit mode each channel passes unchanged.
- R9: In 6-bit mode each channel of `pix_rgb` is {bits 5:0, 2'b00}, using the mode applied in the cycle the pixel index was sampled.
- R10: When strobes coincide, the index write wins over a data write, and a data write wins over a data read. A strobe that loses has no effect.
- R11: A pixel read of the entry being written in the same cycle returns the previous contents, and the new contents from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr_wr | input | 1 | Load the entry index from host_wdata |
| host_data_wr | input | 1 | Write one color byte from host_wdata |
| host_data_rd | input | 1 | Consume one color byte shown on host_rdata |
| host_wdata | input | 8 | Host write data (index or color byte) |
| host_rdata | output | 8 | Color byte selected by the current phase |
| mode_8bit | input | 1 | 1 = 8-bit color, 0 = 6-bit compatible color |
| pix_idx | input | 8 | Pixel index into the table |
| pix_rgb | output | 24 | Formatted color {R,G,B}, one cycle after pix_idx |

## Verification
A wrong phase shows at once, because `host_rdata` then shows the wrong channel, and a lost or extra phase step shifts every later byte. A wrong index or a missed wrap stays hidden until the next read sequence or the next pixel fetch of the affected entry, which then returns another entry's color. A fault in the holding registers or the snapshot corrupts one channel of one entry. The bench therefore compares every host byte and every pixel output each cycle against a model of the table.

// File: rtl/palette_pkg.sv
// Shared definitions for the color palette block.
// Assumes three color channels moved in the order red, green, blue.
package palette_pkg;
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    localparam int NUM_CH = 3;
endpackage

// File: rtl/palette_ram.sv
// Color table storage: one synchronous write port and two asynchronous
// read ports (host snapshot and pixel). A read of an entry being written
// in the same cycle returns the old contents. Not reset, as RAM.
module palette_ram #(
    parameter int AW = 8,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] haddr,
    output logic [DW-1:0] hdata,
    input  logic [AW-1:0] paddr,
    output logic [DW-1:0] pdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [0:DEPTH-1];

    // Write one full color word
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign hdata = mem[haddr];
    assign pdata = mem[paddr];
endmodule

// File: rtl/palette_seq.sv
// Host-side sequencer: entry index, byte phase, write holding registers
// and read snapshot. Priority: index write > data write > data read.
// Assumes the table read port returns data combinationally.
module palette_seq
    import palette_pkg::*;
#(
    parameter int AW   = 8,
    parameter int CW   = 8,
    parameter int MSKW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_wr,
    input  logic            data_wr,
    input  logic            data_rd,
    input  logic [CW-1:0]   wdata,
    input  logic            mode_full,
    output logic            ram_we,
    output logic [AW-1:0]   ram_waddr,
    output logic [3*CW-1:0] ram_wdata,
    output logic [AW-1:0]   fetch_addr,
    input  logic [3*CW-1:0] fetch_data,
    output logic [CW-1:0]   rdata,
    output logic [AW-1:0]   addr_q,
    output logic [1:0]      phase_q
);
    localparam int WW = 3 * CW;

    phase_e          phase;
    logic [AW-1:0]   idx;
    logic [CW-1:0]   hold_r, hold_g;
    logic [WW-1:0]   snap;
    logic            wr_step, rd_step, last_byte, advance;
    logic [CW-1:0]   sel_byte;

    assign wr_step   = data_wr && !addr_wr;
    assign rd_step   = data_rd && !addr_wr && !data_wr;
    assign last_byte = (phase == PH_BLU);
    assign advance   = (wr_step || rd_step) && last_byte;

    // Entry to snapshot: new index on an index write, else the next entry
    always_comb begin
        if (addr_wr) fetch_addr = wdata[AW-1:0];
        else         fetch_addr = idx + 1'b1;
    end

    // Index, phase and holding register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            phase  <= PH_RED;
            hold_r <= '0;
            hold_g <= '0;
            snap   <= '0;
        end else if (addr_wr) begin
            idx   <= wdata[AW-1:0];
            phase <= PH_RED;
            snap  <= fetch_data;
        end else if (wr_step || rd_step) begin
            unique case (phase)
                PH_RED: begin
                    if (wr_step) hold_r <= wdata;
                    phase <= PH_GRN;
                end
                PH_GRN: begin
                    if (wr_step) hold_g <= wdata;
                    phase <= PH_BLU;
                end
                default: begin
                    idx   <= idx + 1'b1;
                    phase <= PH_RED;
                    snap  <= fetch_data;
                end
            endcase
        end
    end

    assign ram_we    = wr_step && last_byte;
    assign ram_waddr = idx;
    assign ram_wdata = {hold_r, hold_g, wdata};

    // Pick the snapshot byte for the current phase
    always_comb begin
        unique case (phase)
            PH_RED:  sel_byte = snap[WW-1 -: CW];
            PH_GRN:  sel_byte = snap[2*CW-1 -: CW];
            default: sel_byte = snap[CW-1:0];
        endcase
    end

    // Clear the upper bits in the narrow mode
    always_comb begin
        rdata = sel_byte;
        if (!mode_full) rdata[CW-1 -: MSKW] = '0;
    end

    assign addr_q  = idx;
    assign phase_q = phase;
endmodule

// File: rtl/palette_pix_fmt.sv
// Pixel output stage: formats each channel of the fetched color and
// registers it, giving one cycle from pixel index to color.
// Assumes channel layout {R,G,B} with red in the top byte.
module palette_pix_fmt #(
    parameter int CW   = 8,
    parameter int MSKW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_full,
    input  logic [3*CW-1:0] color_in,
    output logic [3*CW-1:0] color_out
);
    localparam int NW = CW - MSKW;

    logic [3*CW-1:0] fmt;

    for (genvar c = 0; c < 3; c++) begin : g_ch
        // Pass through or shift the narrow value to the top bits
        always_comb begin
            if (mode_full) fmt[c*CW +: CW] = color_in[c*CW +: CW];
            else           fmt[c*CW +: CW] = {color_in[c*CW +: NW], {MSKW{1'b0}}};
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) color_out <= '0;
        else        color_out <= fmt;
    end
endmodule

// File: rtl/palette_port.sv
// Top: 256 x 24 color table with a byte-serial host port and a
// one-cycle pixel lookup port. Host writes never stall pixel reads.
module palette_port #(
    parameter int AW   = 8,
    parameter int CW   = 8,
    parameter int MSKW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_addr_wr,
    input  logic            host_data_wr,
    input  logic            host_data_rd,
    input  logic [CW-1:0]   host_wdata,
    output logic [CW-1:0]   host_rdata,
    input  logic            mode_8bit,
    input  logic [AW-1:0]   pix_idx,
    output logic [3*CW-1:0] pix_rgb
);
    localparam int WW = 3 * CW;

    logic          ram_we;
    logic [AW-1:0] ram_waddr, fetch_addr, addr_q;
    logic [WW-1:0] ram_wdata, fetch_data, pix_data;
    logic [1:0]    phase_q;

    palette_seq #(.AW(AW), .CW(CW), .MSKW(MSKW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_wr   (host_addr_wr),
        .data_wr   (host_data_wr),
        .data_rd   (host_data_rd),
        .wdata     (host_wdata),
        .mode_full (mode_8bit),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata),
        .fetch_addr(fetch_addr),
        .fetch_data(fetch_data),
        .rdata     (host_rdata),
        .addr_q    (addr_q),
        .phase_q   (phase_q)
    );

    palette_ram #(.AW(AW), .DW(WW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .haddr (fetch_addr),
        .hdata (fetch_data),
        .paddr (pix_idx),
        .pdata (pix_data)
    );

    palette_pix_fmt #(.CW(CW), .MSKW(MSKW)) u_pix (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_full(mode_8bit),
        .color_in (pix_data),
        .color_out(pix_rgb)
    );
endmodule

// File: rtl/palette_port_chk.sv
// Assertion checker for palette_port, attached through bind.
module palette_port_chk #(
    parameter int AW = 8,
    parameter int CW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            addr_wr,
    input logic            data_wr,
    input logic            data_rd,
    input logic [CW-1:0]   wdata,
    input logic [CW-1:0]   rdata,
    input logic            mode_full,
    input logic [3*CW-1:0] pix,
    input logic [AW-1:0]   addr_q,
    input logic [1:0]      phase_q
);
    localparam logic [AW-1:0] LAST = '1;

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q != 2'd3); // R3

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> (phase_q == 2'd0) && (addr_q == $past(wdata[AW-1:0]))); // R5

    AST_STEP_AFTER_BLUE: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_wr && (data_wr || data_rd) && phase_q == 2'd2 && addr_q != LAST)
        |=> (phase_q == 2'd0) && (addr_q == $past(addr_q) + 1'b1)); // R3

    AST_INDEX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_wr && (data_wr || data_rd) && phase_q == 2'd2 && addr_q == LAST)
        |=> addr_q == '0); // R4

    AST_NARROW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_full |-> rdata[CW-1 -: 2] == 2'b00); // R7

    AST_NARROW_PIX: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_full |=> (pix[1:0] == 2'b00) && (pix[CW+1:CW] == 2'b00)
                       && (pix[2*CW+1:2*CW] == 2'b00)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_wr || data_wr || data_rd) |=> $stable(addr_q) && $stable(phase_q)); // R10
endmodule

bind palette_port palette_port_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_wr  (host_addr_wr),
    .data_wr  (host_data_wr),
    .data_rd  (host_data_rd),
    .wdata    (host_wdata),
    .rdata    (host_rdata),
    .mode_full(mode_8bit),
    .pix      (pix_rgb),
    .addr_q   (addr_q),
    .phase_q  (phase_q)
);

// File: tb/palette_port_bench.sv
// Self-checking bench: model of the table and host sequencer, directed
// corner cases plus seeded random traffic.
module palette_port_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        aw, dw, dr, m8;
    logic [7:0]  wd, pidx, rdata;
    logic [23:0] prgb;

    int vec = 0;
    int bad = 0;
    bit done = 0;

    logic [23:0] m_mem [0:255];
    logic [7:0]  m_idx, m_hr, m_hg;
    int          m_ph;
    logic [23:0] m_snap;
    logic [23:0] exp_pix;

    always #5 clk = ~clk;

    palette_port u_palette_port (
        .clk(clk), .rst_n(rst_n),
        .host_addr_wr(aw), .host_data_wr(dw), .host_data_rd(dr),
        .host_wdata(wd), .host_rdata(rdata), .mode_8bit(m8),
        .pix_idx(pidx), .pix_rgb(prgb)
    );

    function automatic logic [7:0] host_view(logic [23:0] w, int ph, logic full);
        logic [7:0] b;
        b = (ph == 0) ? w[23:16] : (ph == 1) ? w[15:8] : w[7:0];
        if (!full) b[7:6] = 2'b00;
        return b;
    endfunction

    function automatic logic [23:0] pix_view(logic [23:0] w, logic full);
        if (full) return w;
        return {w[21:16], 2'b00, w[13:8], 2'b00, w[5:0], 2'b00};
    endfunction

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s host_rdata actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic check24(string tag, logic [23:0] act, logic [23:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s pix_rgb actual=%06h expected=%06h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update model at posedge, check at next negedge
    task automatic cyc(string tag, bit a, bit w, bit r, logic [7:0] d,
                       bit full, logic [7:0] p);
        aw = a; dw = w; dr = r; wd = d; m8 = full; pidx = p;
        exp_pix = pix_view(m_mem[p], full);
        @(posedge clk);
        if (a) begin
            m_idx = d; m_ph = 0; m_snap = m_mem[d];
        end else if (w) begin
            if (m_ph == 0) begin m_hr = d; m_ph = 1; end
            else if (m_ph == 1) begin m_hg = d; m_ph = 2; end
            else begin
                m_mem[m_idx] = {m_hr, m_hg, d};
                m_idx = m_idx + 8'd1; m_ph = 0; m_snap = m_mem[m_idx];
            end
        end else if (r) begin
            if (m_ph == 2) begin
                m_idx = m_idx + 8'd1; m_ph = 0; m_snap = m_mem[m_idx];
            end else m_ph = m_ph + 1;
        end
        @(negedge clk);
        check8(tag, rdata, host_view(m_snap, m_ph, full));
        check24(tag, prgb, exp_pix);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] keep;
        void'($urandom(32'h5EED_C01A));
        aw = 0; dw = 0; dr = 0; wd = 0; m8 = 1; pidx = 0;
        rst_n = 0;
        m_idx = 0; m_ph = 0; m_hr = 0; m_hg = 0; m_snap = 0;
        for (int i = 0; i < 256; i++) m_mem[i] = 24'h0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check8("R1", rdata, 8'h00);
        check24("R1", prgb, 24'h0);

        // R2 R3 R4: fill whole table after one index write, index wraps to 0
        cyc("R5", 1, 0, 0, 8'h00, 1, 8'h00);
        for (int e = 0; e < 256; e++) begin
            cyc("R2", 0, 1, 0, 8'(e ^ 8'hC5), 1, 8'(e));
            cyc("R2", 0, 1, 0, 8'(e * 3),     1, 8'(e));
            cyc("R3", 0, 1, 0, 8'(~e),        1, 8'(e));
        end
        // R4: index back at 0 after 256 entries, read everything again
        for (int e = 0; e < 768; e++)
            cyc("R4", 0, 0, 1, 8'h00, 1, 8'(e));
        // R6: snapshot byte order on a chosen entry
        cyc("R6", 1, 0, 0, 8'd200, 1, 8'd200);
        cyc("R6", 0, 0, 1, 8'h00, 1, 8'd200);
        cyc("R6", 0, 0, 1, 8'h00, 1, 8'd200);

        // R7: narrow mode keeps all bits, masks read-back
        cyc("R7", 1, 0, 0, 8'd9, 0, 8'd9);
        cyc("R7", 0, 1, 0, 8'hFF, 0, 8'd9);
        cyc("R7", 0, 1, 0, 8'hC3, 0, 8'd9);
        cyc("R7", 0, 1, 0, 8'h81, 0, 8'd9);
        cyc("R7", 1, 0, 0, 8'd9, 0, 8'd9);
        cyc("R7", 0, 0, 0, 8'h00, 1, 8'd9);
        // R8 R9: pixel formatting in both modes
        cyc("R8", 0, 0, 0, 8'h00, 1, 8'd9);
        cyc("R9", 0, 0, 0, 8'h00, 0, 8'd9);
        check24("R9", prgb, 24'hFC_0C_04);

        // R5: partial write then index write leaves entry unchanged
        cyc("R5", 1, 0, 0, 8'd40, 1, 8'd40);
        cyc("R5", 0, 1, 0, 8'h11, 1, 8'd40);
        cyc("R5", 0, 1, 0, 8'h22, 1, 8'd40);
        cyc("R5", 1, 0, 0, 8'd40, 1, 8'd40);
        cyc("R5", 0, 0, 1, 8'h00, 1, 8'd40);

        // R10: coincident strobes
        cyc("R10", 1, 1, 1, 8'd77, 1, 8'd0);
        cyc("R10", 0, 1, 1, 8'h5A, 1, 8'd0);
        cyc("R10", 0, 0, 1, 8'h00, 1, 8'd0);

        // R11: pixel read of the entry written this cycle
        cyc("R11", 1, 0, 0, 8'd120, 1, 8'd120);
        cyc("R11", 0, 1, 0, 8'hA1, 1, 8'd120);
        cyc("R11", 0, 1, 0, 8'hB2, 1, 8'd120);
        keep = m_mem[120][7:0];
        cyc("R11", 0, 1, 0, 8'hC3, 1, 8'd120);
        check24("R11", prgb[7:0] == keep ? prgb : 24'hxxxxxx, prgb);
        cyc("R11", 0, 0, 0, 8'h00, 1, 8'd120);
        check24("R11", prgb, 24'hA1_B2_C3);

        // Random mixed traffic
        for (int n = 0; n < 4000; n++) begin
            int   sel;
            bit   a, w, r;
            sel = $urandom_range(0, 99);
            a = (sel < 4);
            w = (sel >= 4 && sel < 50) || (sel > 96);
            r = (sel >= 50 && sel < 92) || (sel > 94);
            cyc("R2", a, w, r, 8'($urandom), ($urandom_range(0, 3) != 0), 8'($urandom));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule